// File: doc/BRIEF.md
# Delta-Modulation Sample Playback Channel

This block plays one-bit delta-coded audio from memory. A reader fetches sample bytes over a request/acknowledge handshake into a one-byte buffer. An output unit consumes each byte bit by bit, least significant bit first. On every rate-timer expiry the unit moves a 7-bit output level up or down by two. Software sets up the channel through four byte-wide write registers: control, direct level load, sample base and sample size. A separate enable strobe, driven from a status register elsewhere in the sound unit, starts or stops playback.

Each fetch raises a stall request toward the processor for as long as the read is outstanding. When the last byte of a sample has been fetched, the channel either restarts from the sample base (loop mode) or raises an interrupt flag, if interrupts are enabled. The rate timer counts in processor cycles and is clocked by a strobe that arrives once per audio tick, which is every second processor cycle.

Top module: `dmc_channel`

## Requirements
- R1: After reset the level is 0, the interrupt flag is low, and no read or stall is requested.
- R2: Register select 0 is control: bit 7 enables the interrupt, bit 6 selects loop mode, bits 3..0 are the rate index. A control write with bit 7 clear drops the interrupt flag.
- R3: A write to register select 1 sets the level to bits 6..0 of the written byte on the next clock. This takes priority over a step in the same cycle.
- R4: With rate index r, output steps occur every P(r)/2 ticks. P is, for r = 0 to 15: 428, 380, 340, 320, 286, 254, 226, 214, 190, 160, 142, 128, 106, 84, 72, 54. A new rate takes effect at the next timer reload.
- R5: On an expiry, a non-silent unit raises the level by 2 when the current bit is 1 and the level is at most 125. It lowers the level by 2 when the bit is 0 and the level is at least 2. Otherwise the level holds. Bits are consumed LSB first, eight per output cycle.
- R6: Register select 2 value A gives a sample start of 0xC000 + 64*A. Register select 3 value L gives a sample size of 16*L + 1 bytes, fetched at consecutive addresses.
- R7: An enable strobe with the enable value high restarts playback only when no bytes remain. With the enable value low it zeroes the remaining bytes, so no new fetch starts, while already buffered bits still play.
- R8: A read request holds with a stable address until acknowledged. The stall request equals the read request.
- R9: The fetch address after 0xFFFF is 0x8000.
- R10: In loop mode, fetching the last byte reloads the start address and size, and no interrupt is raised.
- R11: Outside loop mode, fetching the last byte raises the interrupt flag if interrupts are enabled.
- R12: An output cycle that begins with an empty buffer is silent: the level holds for its eight expiries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| apu_tick | input | 1 | One pulse per audio tick (every second processor cycle) |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 level load, 2 base, 3 size |
| reg_wdata | input | 8 | Register write data |
| en_we | input | 1 | Enable write strobe from the status register |
| en_val | input | 1 | Enable value written |
| rd_req | output | 1 | Sample byte read request |
| rd_addr | output | 16 | Sample byte read address |
| rd_ack | input | 1 | Read acknowledge; rd_data is valid with it |
| rd_data | input | 8 | Read data |
| level | output | 7 | Output level |
| irq | output | 1 | Interrupt flag |
| stall_req | output | 1 | Processor stall request |

## Verification
The assertions assume that memory raises rd_ack only while rd_req is high, for a single cycle, with rd_data valid in that cycle. They also assume that register and enable strobes are single-cycle pulses. The bench's memory responder answers each request once, one cycle after it appears, and drops the acknowledge on the following cycle. All register and enable writes are driven as one-cycle strobes away from the clock edge. The apu_tick strobe is held high continuously, so the step period in clocks equals the number of ticks.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

    localparam int LVL_W   = 7;
    localparam int ADDR_W  = 16;
    localparam int CNT_W   = 9;
    localparam int LEN_W   = 12;
    localparam int STEP    = 2;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_LOAD = 2'd1,
        SEL_BASE = 2'd2,
        SEL_SIZE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic       irq_en;
        logic       loop_en;
        logic [3:0] rate;
        logic [7:0] base;
        logic [7:0] size;
    } cfg_t;

    // Timer period in processor cycles for each rate index.
    function automatic logic [CNT_W-1:0] rate_period(input logic [3:0] r);
        logic [CNT_W-1:0] p;
        case (r)
            4'd0:    p = 9'd428;
            4'd1:    p = 9'd380;
            4'd2:    p = 9'd340;
            4'd3:    p = 9'd320;
            4'd4:    p = 9'd286;
            4'd5:    p = 9'd254;
            4'd6:    p = 9'd226;
            4'd7:    p = 9'd214;
            4'd8:    p = 9'd190;
            4'd9:    p = 9'd160;
            4'd10:   p = 9'd142;
            4'd11:   p = 9'd128;
            4'd12:   p = 9'd106;
            4'd13:   p = 9'd84;
            4'd14:   p = 9'd72;
            default: p = 9'd54;
        endcase
        return p;
    endfunction

    function automatic logic [ADDR_W-1:0] start_addr(input logic [7:0] a);
        return ADDR_W'(16'hC000) + (ADDR_W'(a) << 6);
    endfunction

    function automatic logic [LEN_W-1:0] start_len(input logic [7:0] l);
        return (LEN_W'(l) << 4) + LEN_W'(1);
    endfunction

endpackage

// File: rtl/dmc_rate_timer.sv
module dmc_rate_timer
    import dmc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic [3:0] rate,
    output logic       expire
);
    localparam logic [CNT_W-1:0] DEC = CNT_W'(2);

    logic [CNT_W-1:0] cnt;

    assign expire = tick && (cnt <= DEC);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= rate_period(4'd0);
        end else if (tick) begin
            if (cnt <= DEC) cnt <= rate_period(rate);
            else            cnt <= cnt - DEC;
        end
    end
endmodule

// File: rtl/dmc_reader.sv
module dmc_reader
    import dmc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              loop_en,
    input  logic              irq_en,
    input  logic              irq_clr,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [LEN_W-1:0]  base_len,
    input  logic              en_we,
    input  logic              en_val,
    input  logic              take,
    input  logic              rd_ack,
    input  logic [7:0]        rd_data,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              buf_full,
    output logic [7:0]        buf_data,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] WRAP_TO = {1'b1, {(ADDR_W-1){1'b0}}};

    logic [ADDR_W-1:0] cur_addr;
    logic [LEN_W-1:0]  bytes_left;
    logic [ADDR_W-1:0] next_addr;
    logic              done;

    assign next_addr = (&cur_addr) ? WRAP_TO : cur_addr + ADDR_W'(1);
    assign done      = rd_req && rd_ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_req     <= 1'b0;
            rd_addr    <= '0;
            buf_full   <= 1'b0;
            buf_data   <= '0;
            cur_addr   <= '0;
            bytes_left <= '0;
            irq        <= 1'b0;
        end else begin
            if (!rd_req && !buf_full && bytes_left != '0) begin
                rd_req  <= 1'b1;
                rd_addr <= cur_addr;
            end
            if (done) begin
                rd_req   <= 1'b0;
                buf_full <= 1'b1;
                buf_data <= rd_data;
            end else if (take) begin
                buf_full <= 1'b0;
            end
            if (done && bytes_left != '0) begin
                cur_addr <= next_addr;
                if (bytes_left == LEN_W'(1)) begin
                    if (loop_en) begin
                        cur_addr   <= base_addr;
                        bytes_left <= base_len;
                    end else begin
                        bytes_left <= '0;
                        if (irq_en) irq <= 1'b1;
                    end
                end else begin
                    bytes_left <= bytes_left - LEN_W'(1);
                end
            end
            if (irq_clr) irq <= 1'b0;
            if (en_we) begin
                if (!en_val) begin
                    bytes_left <= '0;
                end else if (bytes_left == '0) begin
                    cur_addr   <= base_addr;
                    bytes_left <= base_len;
                end
            end
        end
    end
endmodule

// File: rtl/dmc_output_unit.sv
module dmc_output_unit
    import dmc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             expire,
    input  logic             buf_full,
    input  logic [7:0]       buf_data,
    input  logic             load_we,
    input  logic [LVL_W-1:0] load_val,
    output logic             take,
    output logic [LVL_W-1:0] level
);
    localparam logic [LVL_W-1:0] STEP_V = LVL_W'(STEP);
    localparam logic [LVL_W-1:0] TOP_OK = {LVL_W{1'b1}} - STEP_V;
    localparam logic [3:0]       NBITS  = 4'd8;

    logic [7:0] shreg;
    logic [3:0] bits_left;
    logic       silent;
    logic       last_bit;

    assign last_bit = (bits_left == 4'd1);
    assign take     = expire && last_bit && buf_full;

    always_ff @(posedge clk) begin
        if (rst) begin
            level     <= '0;
            shreg     <= '0;
            bits_left <= NBITS;
            silent    <= 1'b1;
        end else begin
            if (expire) begin
                if (!silent) begin
                    if (shreg[0] && level <= TOP_OK)
                        level <= level + STEP_V;
                    else if (!shreg[0] && level >= STEP_V)
                        level <= level - STEP_V;
                end
                shreg <= shreg >> 1;
                if (last_bit) begin
                    bits_left <= NBITS;
                    if (buf_full) begin
                        silent <= 1'b0;
                        shreg  <= buf_data;
                    end else begin
                        silent <= 1'b1;
                    end
                end else begin
                    bits_left <= bits_left - 4'd1;
                end
            end
            if (load_we) level <= load_val;
        end
    end
endmodule

// File: rtl/dmc_channel.sv
module dmc_channel
    import dmc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              apu_tick,
    input  logic              reg_we,
    input  logic [1:0]        reg_sel,
    input  logic [7:0]        reg_wdata,
    input  logic              en_we,
    input  logic              en_val,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_ack,
    input  logic [7:0]        rd_data,
    output logic [LVL_W-1:0]  level,
    output logic              irq,
    output logic              stall_req
);
    cfg_t       cfg;
    logic       expire;
    logic       take;
    logic       buf_full;
    logic [7:0] buf_data;
    logic       ctrl_we;
    logic       load_we;

    assign ctrl_we = reg_we && (reg_sel_e'(reg_sel) == SEL_CTRL);
    assign load_we = reg_we && (reg_sel_e'(reg_sel) == SEL_LOAD);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (reg_we) begin
            case (reg_sel_e'(reg_sel))
                SEL_CTRL: begin
                    cfg.irq_en  <= reg_wdata[7];
                    cfg.loop_en <= reg_wdata[6];
                    cfg.rate    <= reg_wdata[3:0];
                end
                SEL_BASE: cfg.base <= reg_wdata;
                SEL_SIZE: cfg.size <= reg_wdata;
                default:  ;
            endcase
        end
    end

    dmc_rate_timer u_timer (
        .clk    (clk),
        .rst    (rst),
        .tick   (apu_tick),
        .rate   (cfg.rate),
        .expire (expire)
    );

    dmc_reader u_reader (
        .clk       (clk),
        .rst       (rst),
        .loop_en   (cfg.loop_en),
        .irq_en    (cfg.irq_en),
        .irq_clr   (ctrl_we && !reg_wdata[7]),
        .base_addr (start_addr(cfg.base)),
        .base_len  (start_len(cfg.size)),
        .en_we     (en_we),
        .en_val    (en_val),
        .take      (take),
        .rd_ack    (rd_ack),
        .rd_data   (rd_data),
        .rd_req    (rd_req),
        .rd_addr   (rd_addr),
        .buf_full  (buf_full),
        .buf_data  (buf_data),
        .irq       (irq)
    );

    dmc_output_unit u_out (
        .clk      (clk),
        .rst      (rst),
        .expire   (expire),
        .buf_full (buf_full),
        .buf_data (buf_data),
        .load_we  (load_we),
        .load_val (reg_wdata[LVL_W-1:0]),
        .take     (take),
        .level    (level)
    );

    assign stall_req = rd_req;
endmodule

// File: rtl/dmc_channel_chk.sv
module dmc_channel_chk (
    input logic        clk,
    input logic        rst,
    input logic        reg_we,
    input logic [1:0]  reg_sel,
    input logic        en_we,
    input logic        en_val,
    input logic        rd_req,
    input logic [15:0] rd_addr,
    input logic        rd_ack,
    input logic [6:0]  level,
    input logic        irq
);
    logic load_w;
    assign load_w = reg_we && (reg_sel == 2'd1);

    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        rd_req && !rd_ack |=> rd_req && $stable(rd_addr));

    // R9
    addr_range_chk: assert property (@(posedge clk) disable iff (rst)
        rd_req |-> rd_addr[15]);

    // R11
    irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(rd_req && rd_ack));

    // R5
    level_step_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(load_w) |-> (level == $past(level)) ||
                           ({1'b0, level} == {1'b0, $past(level)} + 8'd2) ||
                           ({1'b0, level} + 8'd2 == {1'b0, $past(level)}));

    // R7
    disable_no_req_chk: assert property (@(posedge clk) disable iff (rst)
        en_we && !en_val && !rd_req |=> !rd_req);
endmodule

bind dmc_channel dmc_channel_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .reg_we  (reg_we),
    .reg_sel (reg_sel),
    .en_we   (en_we),
    .en_val  (en_val),
    .rd_req  (rd_req),
    .rd_addr (rd_addr),
    .rd_ack  (rd_ack),
    .level   (level),
    .irq     (irq)
);

// File: tb/dmc_channel_tb.sv
module dmc_channel_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        apu_tick = 1'b1;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = '0;
    logic [7:0]  reg_wdata = '0;
    logic        en_we = 1'b0;
    logic        en_val = 1'b0;
    logic        rd_req;
    logic [15:0] rd_addr;
    logic        rd_ack = 1'b0;
    logic [7:0]  rd_data = '0;
    logic [6:0]  level;
    logic        irq;
    logic        stall_req;

    int checks = 0;
    int fails = 0;
    int fetches = 0;
    int cyc = 0;
    logic [7:0]  mem_pat = 8'hFF;
    logic [15:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dmc_channel u_dut (
        .clk(clk), .rst(rst), .apu_tick(apu_tick),
        .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .en_we(en_we), .en_val(en_val),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
        .level(level), .irq(irq), .stall_req(stall_req)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic enable(input logic v);
        @(negedge clk);
        en_we = 1'b1; en_val = v;
        @(negedge clk);
        en_we = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor and memory responder: pops expected fetch addresses.
    always @(negedge clk) begin
        if (rst) begin
            rd_ack = 1'b0;
        end else begin
            checks++;
            if (stall_req !== rd_req) begin
                fails++;
                $display("FAIL R8 stall actual=%0d expected=%0d", stall_req, rd_req);
            end
            if (rd_ack) begin
                rd_ack = 1'b0;
            end else if (rd_req) begin
                fetches++;
                checks++;
                if (exp_q.size() == 0) begin
                    fails++;
                    $display("FAIL R7 unexpected fetch actual=%0h expected=none", rd_addr);
                end else begin
                    logic [15:0] e;
                    e = exp_q.pop_front();
                    if (rd_addr !== e) begin
                        fails++;
                        $display("FAIL %s fetch addr actual=%0h expected=%0h",
                                 (e == 16'h8000) ? "R9" : "R6", rd_addr, e);
                    end
                end
                rd_data = mem_pat;
                rd_ack = 1'b1;
            end
        end
    end

    initial begin
        wait_cyc(WD_CYCLES);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int t1;
        int t2;
        logic [6:0] prev;
        wait_cyc(3);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(level == 7'd0, "R1 level", level, 0);
        check(irq == 1'b0, "R1 irq", irq, 0);
        check(rd_req == 1'b0, "R1 rd_req", rd_req, 0);
        check(stall_req == 1'b0, "R1 stall", stall_req, 0);

        // R3 direct load uses bits 6..0
        wr(2'd1, 8'hC5);
        check(level == 7'h45, "R3 load", level, 7'h45);

        // R2 control: rate 15, irq enabled, no loop; R12 silence with empty buffer
        wr(2'd0, 8'h8F);
        wait_cyc(700);
        check(level == 7'h45, "R12 silent hold", level, 7'h45);
        check(rd_req == 1'b0, "R7 idle no fetch", rd_req, 0);

        // R6 base 0xFFC0, size 65; R9 wrap after 0xFFFF
        wr(2'd2, 8'hFF);
        wr(2'd3, 8'h04);
        for (int a = 16'hFFC0; a <= 16'hFFFF; a++) exp_q.push_back(16'(a));
        exp_q.push_back(16'h8000);
        enable(1'b1);

        // R4 period at rate 15: 27 ticks between steps
        prev = level;
        while (level == prev) @(negedge clk);
        t1 = cyc; prev = level;
        while (level == prev) @(negedge clk);
        t2 = cyc;
        check(t2 - t1 == 27, "R4 period", t2 - t1, 27);
        check(level == 7'h45 + 7'd4, "R5 step up", level, 7'h45 + 4);

        // R7 enable while bytes remain does not restart (monitor checks order)
        enable(1'b1);

        // R5 clamp at top
        begin
            int n = 0;
            while (level != 7'd127 && n < 4000) begin @(negedge clk); n++; end
        end
        check(level == 7'd127, "R5 reach top", level, 127);
        wait_cyc(300);
        check(level == 7'd127, "R5 clamp top", level, 127);

        // R11 irq on completion
        begin
            int n = 0;
            while (!irq && n < 20000) begin @(negedge clk); n++; end
        end
        check(irq == 1'b1, "R11 irq raised", irq, 1);
        check(exp_q.size() == 0, "R6 all bytes fetched", exp_q.size(), 0);
        wait_cyc(700);
        check(rd_req == 1'b0, "R11 no refetch", rd_req, 0);
        check(level == 7'd127, "R12 drained silent", level, 127);

        // R2 control with bit 7 clear drops irq; loop on
        wr(2'd0, 8'h4F);
        check(irq == 1'b0, "R2 irq clear", irq, 0);

        // R10 loop of a one-byte sample at 0xC000, R5 clamp at bottom
        mem_pat = 8'h00;
        wr(2'd1, 8'd3);
        wr(2'd2, 8'h00);
        wr(2'd3, 8'h00);
        for (int i = 0; i < 40; i++) exp_q.push_back(16'hC000);
        fetches = 0;
        enable(1'b1);
        wait_cyc(2000);
        check(level == 7'd1, "R5 clamp bottom", level, 1);
        check(fetches >= 3, "R10 loop refetch", fetches, 3);
        check(irq == 1'b0, "R10 no irq in loop", irq, 0);

        // R7 disable stops further fetches
        @(negedge clk);
        exp_q.delete();
        if (rd_req) exp_q.push_back(16'hC000);
        en_we = 1'b1; en_val = 1'b0;
        @(negedge clk);
        en_we = 1'b0;
        wait_cyc(1500);
        check(rd_req == 1'b0, "R7 disabled", rd_req, 0);
        check(level == 7'd1, "R7 level after disable", level, 1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule